// File: doc/BRIEF.md
# Float to Signed Integer Truncator

This block turns an already unpacked floating-point operand into a two's-complement integer. It always rounds toward zero, so it needs no rounding-mode input. The operand arrives as a sign bit, a class code, a signed unbiased exponent, a normalised mantissa and a sticky bit. The mantissa's leading one sits in its top bit, and the binary point follows that bit.

The result is registered together with two exception flags: inexact and invalid. A value that cannot be represented saturates, and the saturation value depends on the sign. Setting the output width parameter to 64 gives the wide-integer variant with no other change.

A caller presents one operand per cycle with a strobe. One cycle later it reads the integer and the flags, together with a matching valid pulse.

Top module: `fp_int_trunc`

## Requirements
- R1: A zero operand (class code 0) gives the integer 0 with both flags clear, whatever the sign and sticky inputs hold.
- R2: Infinity (code 2), quiet NaN (code 3) and signalling NaN (code 4), and any unused code, are invalid. The result saturates to 0x7FFFFFFF when the sign is clear and to 0x80000000 when it is set, and inexact is clear.
- R3: A number (code 1) whose exponent is at least the output width (32) is invalid and saturates as in R2, even when its sticky bit is set.
- R4: For a number, the value is mantissa × 2^(exponent − 63), where the mantissa is 64 bits wide. The integer part of its magnitude is kept and the fraction is discarded. A set sign returns the two's-complement negation of that magnitude.
- R5: Inexact is raised for a non-overflowing number when any discarded fraction bit is one or the sticky input is set. A negative exponent gives 0 with inexact.
- R6: A positive number whose integer magnitude is 2^31 or more is invalid and returns 0x7FFFFFFF. Invalid and inexact are never raised together.
- R7: A negative number whose integer magnitude is exactly 2^31 returns 0x80000000 without invalid. Inexact in that case follows R5. A larger magnitude is invalid and returns 0x80000000.
- R8: The result and flags appear, with a one-cycle valid pulse, on the clock edge after the edge that samples the input strobe. While no strobe is present they hold their last values and valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_exp | input | EXP_W (16) | Signed unbiased exponent |
| in_mant | input | MANT_W (64) | Normalised mantissa, leading one in top bit |
| in_sticky | input | 1 | OR of bits already lost below the mantissa |
| out_valid | output | 1 | Result valid pulse |
| out_int | output | OUT_W (32) | Truncated integer |
| out_inexact | output | 1 | Fraction was discarded |
| out_invalid | output | 1 | Operand not representable, result saturated |

## Verification
The properties assume that any operand of class "number" carries a mantissa whose top bit is set. The truncation and limit checks rely on that leading one, so a denormalised input would make their outcomes meaningless. The directed stimulus only builds normalised mantissas for class 1 and leaves the mantissa at arbitrary values only for the other classes, where it must be ignored. The exponent stays inside its signed range and spans negative, small, boundary (30, 31, 32) and very large values.

// File: rtl/fp_int_trunc_pkg.sv
package fp_int_trunc_pkg;

   typedef enum logic [2:0] {
      FC_ZERO = 3'd0,
      FC_NUM  = 3'd1,
      FC_INF  = 3'd2,
      FC_QNAN = 3'd3,
      FC_SNAN = 3'd4
   } fclass_e;

   // saturation patterns for a given integer width
   function automatic logic [127:0] sat_pos(input int w);
      logic [127:0] v;
      v = '0;
      for (int i = 0; i < w - 1; i++) v[i] = 1'b1;
      return v;
   endfunction

   function automatic logic [127:0] sat_neg(input int w);
      logic [127:0] v;
      v = '0;
      v[w-1] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/fp_int_trunc_range.sv
// Operand classification and shift-distance computation.
module fp_int_trunc_range
   import fp_int_trunc_pkg::*;
#(
   parameter int OUT_W  = 32,
   parameter int MANT_W = 64,
   parameter int EXP_W  = 16,
   parameter int SH_W   = 7
) (
   input  logic [2:0]       cls,
   input  logic [EXP_W-1:0] exp_in,
   output logic             is_num,
   output logic             force_ovf,
   output logic [SH_W-1:0]  amt
);

   localparam logic signed [EXP_W-1:0] EXP_LIM  = EXP_W'(OUT_W);
   localparam logic [SH_W-1:0]         AMT_TOP  = SH_W'(MANT_W - 1);
   localparam logic [SH_W-1:0]         AMT_ALL  = SH_W'(MANT_W);

   logic signed [EXP_W-1:0] exp_s;
   logic                    exp_big;
   logic                    exp_neg;
   fclass_e                 cls_e;

   always_comb begin
      cls_e     = fclass_e'(cls);
      exp_s     = $signed(exp_in);
      exp_big   = exp_s >= EXP_LIM;
      exp_neg   = exp_s[EXP_W-1];
      is_num    = (cls_e == FC_NUM);
      force_ovf = 1'b0;
      if (cls_e != FC_ZERO && cls_e != FC_NUM) force_ovf = 1'b1;
      if (is_num && exp_big)                   force_ovf = 1'b1;
      if (exp_neg)       amt = AMT_ALL;
      else if (exp_big)  amt = '0;
      else               amt = AMT_TOP - exp_in[SH_W-1:0];
   end

endmodule

// File: rtl/fp_int_trunc_shift.sv
// Logarithmic right shifter that also reports whether any one bit fell off.
module fp_int_trunc_shift #(
   parameter int MANT_W = 64,
   parameter int SH_W   = 7
) (
   input  logic [MANT_W-1:0] din,
   input  logic [SH_W-1:0]   amt,
   output logic [MANT_W-1:0] dout,
   output logic              lost
);

   localparam logic [MANT_W-1:0] ONE = MANT_W'(1);

   logic [MANT_W-1:0] stage [0:SH_W];
   logic [SH_W:0]     drop;

   assign stage[0] = din;
   assign drop[0]  = 1'b0;

   for (genvar k = 0; k < SH_W; k++) begin : g_stage
      localparam longint DIST = longint'(1) << k;
      if (DIST >= MANT_W) begin : g_flush
         assign stage[k+1] = amt[k] ? '0 : stage[k];
         assign drop[k+1]  = drop[k] | (amt[k] & (|stage[k]));
      end else begin : g_part
         localparam logic [MANT_W-1:0] MASK = (ONE << DIST) - ONE;
         assign stage[k+1] = amt[k] ? (stage[k] >> DIST) : stage[k];
         assign drop[k+1]  = drop[k] | (amt[k] & (|(stage[k] & MASK)));
      end
   end

   assign dout = stage[SH_W];
   assign lost = drop[SH_W];

endmodule

// File: rtl/fp_int_trunc_sat.sv
// Limit check, saturation, negation and flag generation.
module fp_int_trunc_sat
   import fp_int_trunc_pkg::*;
#(
   parameter int OUT_W  = 32,
   parameter int MANT_W = 64
) (
   input  logic [MANT_W-1:0] mag,
   input  logic              sign,
   input  logic              is_num,
   input  logic              force_ovf,
   input  logic              lost,
   input  logic              sticky,
   output logic [OUT_W-1:0]  res,
   output logic              inexact,
   output logic              invalid
);

   localparam logic [OUT_W-1:0] MAX_POS = OUT_W'(sat_pos(OUT_W));
   localparam logic [OUT_W-1:0] MIN_NEG = OUT_W'(sat_neg(OUT_W));

   logic             hi_any;
   logic             msb;
   logic             rest_any;
   logic             ovf_mag;
   logic             ovf;
   logic [OUT_W-1:0] m;

   if (OUT_W < MANT_W) begin : g_narrow
      assign hi_any = |mag[MANT_W-1:OUT_W];
   end else begin : g_full
      assign hi_any = 1'b0;
   end

   always_comb begin
      m        = mag[OUT_W-1:0];
      msb      = m[OUT_W-1];
      rest_any = |m[OUT_W-2:0];
      ovf_mag  = hi_any | (msb & (~sign | rest_any));
      ovf      = force_ovf | (is_num & ovf_mag);
      if (ovf)         res = sign ? MIN_NEG : MAX_POS;
      else if (is_num) res = sign ? (~m + OUT_W'(1)) : m;
      else             res = '0;
      inexact  = is_num & ~ovf & (lost | sticky);
      invalid  = ovf;
   end

endmodule

// File: rtl/fp_int_trunc.sv
module fp_int_trunc
   import fp_int_trunc_pkg::*;
#(
   parameter int OUT_W  = 32,
   parameter int MANT_W = 64,
   parameter int EXP_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sign,
   input  logic [2:0]        in_class,
   input  logic [EXP_W-1:0]  in_exp,
   input  logic [MANT_W-1:0] in_mant,
   input  logic              in_sticky,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_int,
   output logic              out_inexact,
   output logic              out_invalid
);

   localparam int SH_W = $clog2(MANT_W + 1);

   if (OUT_W < 2 || OUT_W > 64) begin : g_chk_out
      $error("OUT_W must lie in 2..64");
   end
   if (MANT_W < OUT_W || MANT_W > 128) begin : g_chk_mant
      $error("MANT_W must be at least OUT_W and at most 128");
   end
   if (EXP_W <= SH_W) begin : g_chk_exp
      $error("EXP_W too narrow for the shift range");
   end

   logic              is_num;
   logic              force_ovf;
   logic [SH_W-1:0]   amt;
   logic [MANT_W-1:0] mag;
   logic              lost;
   logic [OUT_W-1:0]  res_c;
   logic              inexact_c;
   logic              invalid_c;

   fp_int_trunc_range #(
      .OUT_W(OUT_W), .MANT_W(MANT_W), .EXP_W(EXP_W), .SH_W(SH_W)
   ) u_range (
      .cls       (in_class),
      .exp_in    (in_exp),
      .is_num    (is_num),
      .force_ovf (force_ovf),
      .amt       (amt)
   );

   fp_int_trunc_shift #(
      .MANT_W(MANT_W), .SH_W(SH_W)
   ) u_shift (
      .din  (in_mant),
      .amt  (amt),
      .dout (mag),
      .lost (lost)
   );

   fp_int_trunc_sat #(
      .OUT_W(OUT_W), .MANT_W(MANT_W)
   ) u_sat (
      .mag       (mag),
      .sign      (in_sign),
      .is_num    (is_num),
      .force_ovf (force_ovf),
      .lost      (lost),
      .sticky    (in_sticky),
      .res       (res_c),
      .inexact   (inexact_c),
      .invalid   (invalid_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_int     <= '0;
         out_inexact <= 1'b0;
         out_invalid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_int     <= res_c;
            out_inexact <= inexact_c;
            out_invalid <= invalid_c;
         end
      end
   end

endmodule

// File: rtl/fp_int_trunc_chk.sv
module fp_int_trunc_chk
   import fp_int_trunc_pkg::*;
#(
   parameter int OUT_W = 32,
   parameter int EXP_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_sign,
   input logic [2:0]       in_class,
   input logic [EXP_W-1:0] in_exp,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_int,
   input logic             out_inexact,
   input logic             out_invalid
);

   localparam logic [OUT_W-1:0] MAX_POS = OUT_W'(sat_pos(OUT_W));
   localparam logic [OUT_W-1:0] MIN_NEG = OUT_W'(sat_neg(OUT_W));
   localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(OUT_W);

   AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_class == 3'd0 |=> out_int == '0 && !out_inexact && !out_invalid); // R1
   AST_SPECIAL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_class >= 3'd2 |=> out_invalid && !out_inexact); // R2
   AST_SPECIAL_NEG_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_class >= 3'd2 && in_sign |=> out_int == MIN_NEG); // R2
   AST_BIG_EXP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_class == 3'd1 && $signed(in_exp) >= EXP_LIM |=> out_invalid); // R3
   AST_NEG_EXP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_class == 3'd1 && $signed(in_exp) < 0 |=> out_int == '0 && out_inexact && !out_invalid); // R5
   AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_invalid |-> out_int == MAX_POS || out_int == MIN_NEG); // R6
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_invalid && out_inexact)); // R6
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R8
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_int) && $stable(out_inexact) && $stable(out_invalid)); // R8

endmodule

bind fp_int_trunc fp_int_trunc_chk #(
   .OUT_W(OUT_W), .EXP_W(EXP_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_sign     (in_sign),
   .in_class    (in_class),
   .in_exp      (in_exp),
   .out_valid   (out_valid),
   .out_int     (out_int),
   .out_inexact (out_inexact),
   .out_invalid (out_invalid)
);

// File: tb/fp_int_trunc_bench.sv
module fp_int_trunc_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sign = 1'b0;
   logic [2:0]  in_class = 3'd0;
   logic [15:0] in_exp = '0;
   logic [63:0] in_mant = '0;
   logic        in_sticky = 1'b0;
   logic        out_valid;
   logic [31:0] out_int;
   logic        out_inexact;
   logic        out_invalid;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fp_int_trunc u_fp_int_trunc (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
      .in_class(in_class), .in_exp(in_exp), .in_mant(in_mant),
      .in_sticky(in_sticky), .out_valid(out_valid), .out_int(out_int),
      .out_inexact(out_inexact), .out_invalid(out_invalid)
   );

   task automatic check(input string req, input logic [31:0] e_int,
                        input logic e_inx, input logic e_inv, input logic e_vld);
      n_chk++;
      if (out_int !== e_int || out_inexact !== e_inx ||
          out_invalid !== e_inv || out_valid !== e_vld) begin
         n_bad++;
         $display("FAIL %s: got int=%h inx=%b inv=%b vld=%b, want int=%h inx=%b inv=%b vld=%b",
                  req, out_int, out_inexact, out_invalid, out_valid,
                  e_int, e_inx, e_inv, e_vld);
      end
   endtask

   // drive one operand, then sample the registered result
   task automatic apply(input logic s, input logic [2:0] c, input int e,
                        input logic [63:0] m, input logic st);
      @(negedge clk);
      in_valid = 1'b1; in_sign = s; in_class = c;
      in_exp = 16'(e); in_mant = m; in_sticky = st;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R8 reset", 32'h0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_zero();
      apply(1'b1, 3'd0, 5, 64'hDEAD_BEEF_0000_0001, 1'b1);
      check("R1 zero", 32'h0, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_specials();
      apply(1'b0, 3'd2, 0, 64'h8000_0000_0000_0000, 1'b1);
      check("R2 +inf", 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1);
      apply(1'b1, 3'd2, 0, 64'h8000_0000_0000_0000, 1'b0);
      check("R2 -inf", 32'h8000_0000, 1'b0, 1'b1, 1'b1);
      apply(1'b0, 3'd3, 0, 64'hC000_0000_0000_0000, 1'b0);
      check("R2 qnan", 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1);
      apply(1'b1, 3'd4, 0, 64'hA000_0000_0000_0000, 1'b0);
      check("R2 snan", 32'h8000_0000, 1'b0, 1'b1, 1'b1);
   endtask

   task automatic t_big_exp();
      apply(1'b0, 3'd1, 32, 64'h8000_0000_0000_0000, 1'b1);
      check("R3 exp32 pos", 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1);
      apply(1'b1, 3'd1, 1000, 64'hFFFF_0000_0000_0000, 1'b0);
      check("R3 exp1000 neg", 32'h8000_0000, 1'b0, 1'b1, 1'b1);
   endtask

   task automatic t_truncate();
      apply(1'b0, 3'd1, 0, 64'h8000_0000_0000_0000, 1'b0);
      check("R4 one", 32'd1, 1'b0, 1'b0, 1'b1);
      apply(1'b0, 3'd1, 3, 64'hC000_0000_0000_0000, 1'b0);
      check("R4 twelve", 32'd12, 1'b0, 1'b0, 1'b1);
      apply(1'b1, 3'd1, 3, 64'hC000_0000_0000_0000, 1'b0);
      check("R4 minus twelve", 32'hFFFF_FFF4, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_inexact();
      apply(1'b0, 3'd1, 2, 64'hB800_0000_0000_0000, 1'b0);
      check("R5 5.75", 32'd5, 1'b1, 1'b0, 1'b1);
      apply(1'b1, 3'd1, 2, 64'hB800_0000_0000_0000, 1'b0);
      check("R5 -5.75", 32'hFFFF_FFFB, 1'b1, 1'b0, 1'b1);
      apply(1'b0, 3'd1, 3, 64'hC000_0000_0000_0000, 1'b1);
      check("R5 sticky only", 32'd12, 1'b1, 1'b0, 1'b1);
      apply(1'b1, 3'd1, -1, 64'h8000_0000_0000_0000, 1'b0);
      check("R5 -0.5", 32'h0, 1'b1, 1'b0, 1'b1);
      apply(1'b0, 3'd1, 30, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      check("R5 largest below limit", 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_pos_limit();
      apply(1'b0, 3'd1, 31, 64'h8000_0000_0000_0000, 1'b0);
      check("R6 +2^31", 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1);
      apply(1'b0, 3'd1, 31, 64'h8000_0000_0000_0001, 1'b1);
      check("R6 +2^31 inexact cleared", 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1);
   endtask

   task automatic t_neg_limit();
      apply(1'b1, 3'd1, 31, 64'h8000_0000_0000_0000, 1'b0);
      check("R7 -2^31 exact", 32'h8000_0000, 1'b0, 1'b0, 1'b1);
      apply(1'b1, 3'd1, 31, 64'h8000_0000_8000_0000, 1'b0);
      check("R7 -2^31 with fraction", 32'h8000_0000, 1'b1, 1'b0, 1'b1);
      apply(1'b1, 3'd1, 31, 64'h8000_0001_0000_0000, 1'b0);
      check("R7 below -2^31", 32'h8000_0000, 1'b0, 1'b1, 1'b1);
   endtask

   task automatic t_timing();
      @(negedge clk);
      in_valid = 1'b1; in_sign = 1'b0; in_class = 3'd1;
      in_exp = 16'd4; in_mant = 64'h8800_0000_0000_0000; in_sticky = 1'b0;
      @(negedge clk);
      check("R8 first of pair", 32'd17, 1'b0, 1'b0, 1'b1);
      in_sign = 1'b1; in_exp = 16'd1; in_mant = 64'hE000_0000_0000_0000;
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 second of pair", 32'hFFFF_FFFD, 1'b1, 1'b0, 1'b1);
      in_sign = 1'b0; in_class = 3'd2; in_exp = 16'd7;
      in_mant = 64'h0; in_sticky = 1'b1;
      @(negedge clk);
      check("R8 hold without strobe", 32'hFFFF_FFFD, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      check("R8 hold later", 32'hFFFF_FFFD, 1'b1, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not end, got timeout, want completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 2 + 1);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_zero();
      t_specials();
      t_big_exp();
      t_truncate();
      t_inexact();
      t_pos_limit();
      t_neg_limit();
      t_timing();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule